// File: doc/BRIEF.md
# Sticky-Enable Watchdog Timer

This block guards a processor against runaway software. It holds a 13-bit free-running counter and one control bit that sits in a small register reachable over a simple register write/read port. The watchdog starts disabled after system reset. Software turns it on by writing a one into the control bit, and after that no software write can turn it off again. Every later write of one into the same bit is a service operation: it clears the counter and starts a new full period.

If software stops servicing the watchdog for 2^13 system clocks, the counter runs out and the block pulses a reset request for one clock. The counter keeps running after that, so a system that ignores the request gets another pulse each period. A freeze input stops the counter while the processor sits halted in its stop mode, and the period resumes where it left off. Only system reset clears the enable and the count.

Top module: `wdog_sticky`

## Requirements
- R1: After system reset the watchdog is disabled, `wdog_rst_req` is 0 and a read of address 0x0C returns 0x00.
- R2: A write with `bus_wr`=1, `bus_addr`=0x0C and `bus_wdata` bit 0 = 1 enables the watchdog. While it is enabled, a read of address 0x0C returns 0x01 (bit 0 set, all other bits 0).
- R3: Once the watchdog is enabled, no write turns it off. A write to 0x0C with bit 0 = 0 leaves the enable set and does not move the time of the next request.
- R4: `wdog_rst_req` is high for exactly one clock. It rises on the 2^13-th rising clock edge after the edge that took the last enabling or servicing write.
- R5: While the watchdog is disabled, `wdog_rst_req` stays 0 however long the clock runs.
- R6: A write of bit 0 = 1 to 0x0C while enabled restarts the count, and the next request moves to 2^13 edges after that write.
- R7: A servicing write taken on the same edge on which the count would expire wins. No request is made on that edge, and the next request comes 2^13 edges later.
- R8: While `stop_freeze` is 1 the count holds and no request is made. Each frozen edge delays the pending request by one clock.
- R9: Writes to any address other than 0x0C have no effect on the watchdog, and reads of other addresses return 0x00.
- R10: System reset taken while the watchdog is enabled clears both the enable and the count.
- R11: If the watchdog is not serviced after a request, the counter wraps and requests again 2^13 edges after the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address for both writes and reads |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| stop_freeze | input | 1 | Holds the counter while the processor is stopped |
| wdog_rst_req | output | 1 | One-clock system reset request on timeout |

## Verification
A servicing write and the expiry of the count can land on the same clock edge. The bench provokes this by counting edges from the previous service, waiting until the edge just before the predicted expiry, and issuing the write so that it is taken on exactly the expiry edge. The scoreboard then expects no pulse on that edge and a new pulse one full period later. A freeze window placed over a pending expiry is judged the same way: the predicted pulse is shifted by the number of frozen edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned BUS_AW = 6;
    localparam int unsigned BUS_DW = 8;
    localparam logic [BUS_AW-1:0] CTRL_ADDR = 6'h0C;

    typedef struct packed {
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } reg_wr_t;

    // Control-register decode, shared by the write and read paths.
    function automatic logic ctrl_hit(input logic [BUS_AW-1:0] addr);
        return addr == CTRL_ADDR;
    endfunction

    // True when a write both addresses the control register and carries a one in the service bit.
    function automatic logic is_service(input reg_wr_t w, input int unsigned bitpos);
        return w.wr && ctrl_hit(w.addr) && w.data[bitpos];
    endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned KICK_BIT = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr_req,
    output logic    kick,
    output logic    armed
);

    logic armed_q;

    assign kick  = is_service(wr_req, KICK_BIT);
    assign armed = armed_q;

    // The enable sets on a service write and is never cleared except by reset.
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (kick)
            armed_q <= 1'b1;
    end

    // R3
    armed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q |=> armed_q);

    // R2
    kick_arms_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> armed_q);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned CNT_W = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic kick,
    input  logic freeze,
    output logic expire
);

    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic             advance;
    logic             at_end;

    assign advance = armed && !freeze && !kick;
    assign at_end  = cnt_q == CNT_LAST;
    assign expire  = req_q;

    // A service write outranks the expiry; the counter wraps after a timeout.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= advance && at_end;
            if (kick)
                cnt_q <= '0;
            else if (advance)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R5
    req_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> armed);

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !kick) |=> ($stable(cnt_q) && !req_q));

    // R6
    kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0 && !req_q));

endmodule

// File: rtl/wdog_sticky.sv
module wdog_sticky
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W    = 13,
    parameter int unsigned KICK_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              stop_freeze,
    output logic              wdog_rst_req
);

    localparam logic [BUS_DW-1:0] KICK_MASK = BUS_DW'(1) << KICK_BIT;

    reg_wr_t wr_req;
    logic    kick;
    logic    armed;
    logic    unused_wdata;

    assign wr_req       = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign unused_wdata = ^(bus_wdata & ~KICK_MASK);

    wdog_ctrl #(
        .KICK_BIT(KICK_BIT)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_req(wr_req),
        .kick  (kick),
        .armed (armed)
    );

    wdog_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .armed (armed),
        .kick  (kick),
        .freeze(stop_freeze),
        .expire(wdog_rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit(bus_addr))
            bus_rdata[KICK_BIT] = armed;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!wdog_rst_req && bus_rdata == '0 || !ctrl_hit(bus_addr)));

endmodule

// File: tb/wdog_sticky_test.sv
`timescale 1ns/1ps
module wdog_sticky_test;

    localparam int PERIOD = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = 6'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_freeze = 1'b0;
    logic       wdog_rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    int exp_q[$];

    wdog_sticky uut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .stop_freeze (stop_freeze),
        .wdog_rst_req(wdog_rst_req)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares the request pin against the predicted pulse edges.
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0 && cyc == exp_q[0]) begin
                n_cmp++;
                if (wdog_rst_req !== 1'b1) begin
                    n_bad++;
                    $display("FAIL R4: request at edge %0d act=%b exp=1", cyc, wdog_rst_req);
                end
                void'(exp_q.pop_front());
            end else if (wdog_rst_req !== 1'b0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R5/R7: unexpected request at edge %0d act=%b exp=0", cyc, wdog_rst_req);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic wait_edge(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d, output int e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        e = cyc;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic read_reg(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Driver: a service write replaces the pending prediction.
    task automatic service(output int e);
        bus_write(6'h0C, 8'h01, e);
        exp_q.delete();
        exp_q.push_back(e + PERIOD);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        int e;
        int t;
        logic [7:0] rd;
        do_reset();
        // R1
        read_reg(6'h0C, rd);
        check("R1 ctrl read after reset", rd, 8'h00);
        check("R1 request after reset", {7'd0, wdog_rst_req}, 8'h00);

        // R3 / R5: writing zero while disabled does nothing
        bus_write(6'h0C, 8'h00, e);
        read_reg(6'h0C, rd);
        check("R5 zero write keeps disabled", rd, 8'h00);
        // R9: a service pattern at neighbouring addresses is ignored
        bus_write(6'h0D, 8'h01, e);
        bus_write(6'h0B, 8'hFF, e);
        read_reg(6'h0C, rd);
        check("R9 other-address writes ignored", rd, 8'h00);
        wait_edge(cyc + PERIOD + 200);   // R5: monitor flags any pulse

        // R2: enable
        service(e);
        read_reg(6'h0C, rd);
        check("R2 enabled readback", rd, 8'h01);
        read_reg(6'h0D, rd);
        check("R9 other-address read", rd, 8'h00);

        // R3: zero write cannot disable, timing unchanged
        wait_edge(e + 3000);
        bus_write(6'h0C, 8'hFE, t);
        read_reg(6'h0C, rd);
        check("R3 still enabled after zero write", rd, 8'h01);

        // R4 then R11: first pulse, then a wrapped second pulse
        t = exp_q[0];
        exp_q.push_back(t + PERIOD);
        wait_edge(t + PERIOD + 3);
        check("R11 both pulses observed", 8'(exp_q.size()), 8'h00);

        // R6: service well before expiry moves the deadline
        service(e);
        wait_edge(exp_q[0] - 100);
        service(e);
        wait_edge(e + 50);
        check("R6 pending pulse retargeted", 8'(exp_q.size()), 8'h01);

        // R7: service on exactly the expiry edge
        t = exp_q[0];
        wait_edge(t - 1);
        service(e);
        check("R7 write landed on expiry edge", 8'(e - t), 8'h00);

        // R8: freeze over the pending expiry
        wait_edge(e + 1000);
        @(negedge clk);
        stop_freeze = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        stop_freeze = 1'b0;
        exp_q[0] = exp_q[0] + 300;
        wait_edge(exp_q[0] + 3);
        check("R8 delayed pulse observed", 8'(exp_q.size()), 8'h00);

        // R10: reset while enabled
        service(e);
        wait_edge(e + 4000);
        do_reset();
        read_reg(6'h0C, rd);
        check("R10 reset clears enable", rd, 8'h00);
        wait_edge(cyc + PERIOD + 200);
        check("R10 no pending prediction left", 8'(exp_q.size()), 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule